// File: doc/BRIEF.md
# RC-Ramp Successive Approximation Controller

This block turns a single comparator bit and a single digital drive pin into an N-bit analog-to-digital conversion. An external resistor-capacitor node is charged or discharged by the drive pin. The comparator reports whether the analog input is above that node. There is no DAC. Each trial level is built by holding the drive pin for a binary-weighted number of clocks. The first window is long enough to ramp the node to half of full scale. Every later window is half as long as the one before it, and its polarity is set by the previous bit decision: drive high after a 1, drive low after a 0.

A conversion begins with a discharge period, during which the pin is held low so that the node starts near ground. The windows follow, from the MSB down to the LSB. The comparator bit is resynchronised before use. The decision for each bit is taken on the last clock of its window.

Several analog inputs can share one controller. Each input has its own comparator and RC network, and an external multiplexer picks one comparator under the control of the channel-select output. Channel select steps round-robin each time a conversion completes.

Top module: `rcsar_ctrl`

## Requirements
- R1: While reset is held, and at release, `rc_drive`, `done`, `result` and `ch_sel` are all 0.
- R2: A `start` accepted while idle begins a discharge period of exactly DISCH_CYCLES clocks, during which `rc_drive` is 0 and `done` is 0.
- R3: The first window (MSB) follows the discharge directly. It holds `rc_drive` at 1 for BASE_TICKS*2^(RES_BITS-1) clocks.
- R4: The window for result bit k lasts BASE_TICKS*2^k clocks, so each window is half the length of the one before it.
- R5: In every window after the first, `rc_drive` equals the bit decided in the window just before it: 1 drives the node up, 0 drives it down.
- R6: Result bit k is the comparator level on the last clock of window k, after a two-flop synchroniser. A comparator value of 1 means the analog input is above the RC node and gives a result bit of 1. Bits are decided MSB first.
- R7: `done` pulses high for exactly one clock, in the cycle after the LSB window ends. `result` takes the new code in that same cycle and holds its value at all other times.
- R8: `ch_sel` advances by one in the cycle `done` is high, wraps from NUM_CH-1 to 0, and is otherwise stable.
- R9: A `start` that arrives during the discharge period or any window has no effect. Window timing, drive levels, `result`, `ch_sel` and `done` are unchanged.
- R10: A `start` in the cycle `done` is high is accepted, so conversions can run back to back.
- R11: When the LSB is decided, `rc_drive` returns to 0 and stays 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a conversion when idle |
| cmp_in | input | 1 | Asynchronous comparator bit, 1 when the analog input is above the RC node |
| rc_drive | output | 1 | Level applied to the RC network |
| ch_sel | output | CH_W | Selects which comparator the external multiplexer passes |
| done | output | 1 | One-clock strobe when a conversion completes |
| result | output | RES_BITS | Converted code, MSB first |

## Verification
The bench builds the controller with RES_BITS=5, BASE_TICKS=4, DISCH_CYCLES=6 and NUM_CH=3. With these values the shortest window is four clocks, which is longer than the synchroniser delay, so a comparator level set at the start of a window is the level decided at its end. This allows exact bit patterns, including alternating ones, to be steered in and checked against the drive polarity of every window. Three channels make the non-power-of-two wrap of the channel select reachable within a few conversions. The short discharge period keeps a full conversion near 130 cycles, which leaves room for start strobes placed in the discharge period, in a middle window and in the LSB window, and for back-to-back starts.

// File: rtl/rcsar_pkg.sv
`timescale 1ns/1ps
// Shared types for the RC-ramp successive approximation controller.
// Assumes: only the sequencer drives the state; the checker only reads it.
package rcsar_pkg;

    // Phases of one conversion
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DISCH = 2'd1,
        ST_WIN   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rcsar_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the asynchronous comparator bit.
// Assumes: the input changes slowly compared with clk; the output is
// delayed by STAGES clocks.
module rcsar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // First stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_async;
    end

    // Remaining stages shift the value along
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rcsar_timer.sv
`timescale 1ns/1ps
// Down-counter that times the discharge period and each drive window.
// Assumes: load_val is the window length minus one; 'last' is high on
// the final clock of the timed interval (counter at zero).
module rcsar_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/rcsar_chan.sv
`timescale 1ns/1ps
// Round-robin channel pointer for the external comparator multiplexer.
// Assumes: 'step' is high for exactly one clock per finished conversion.
module rcsar_chan #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [CH_W-1:0] ch
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    // Advance the pointer on each completed conversion, wrapping at the end
    always_ff @(posedge clk) begin
        if (!rst_n)          ch <= '0;
        else if (step) begin
            if (ch == LAST_CH) ch <= '0;
            else               ch <= ch + 1'b1;
        end
    end

endmodule

// File: rtl/rcsar_seq.sv
`timescale 1ns/1ps
// Conversion sequencer: discharge, then one binary-weighted drive window
// per bit from MSB to LSB. It decides each bit from the synchronised
// comparator on the last clock of its window.
// Assumes: the timer reports 'tmr_last' on the final clock of the
// interval it was loaded with; windows are at least as long as the
// synchroniser delay plus one for the decision to see the window's level.
module rcsar_seq #(
    parameter int RES_BITS     = 8,
    parameter int BASE_TICKS   = 2,
    parameter int DISCH_CYCLES = 64,
    parameter int CNT_W        = 8,
    parameter int IDX_W        = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cmp_s,
    input  logic                   tmr_last,
    output logic                   tmr_load,
    output logic [CNT_W-1:0]       tmr_val,
    output logic                   finish,
    output logic                   rc_drive,
    output logic                   done,
    output logic [RES_BITS-1:0]    result,
    output rcsar_pkg::seq_state_t  state_o
);
    import rcsar_pkg::*;

    localparam logic [CNT_W-1:0] DISCH_M1 = CNT_W'(DISCH_CYCLES - 1);
    localparam logic [IDX_W-1:0] MSB_IDX  = IDX_W'(RES_BITS - 1);

    seq_state_t          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [RES_BITS-1:0] acc_q;
    logic [RES_BITS-1:0] acc_nx;
    logic [CNT_W-1:0]    win_m1 [RES_BITS];

    // Window length table: bit k is driven for BASE_TICKS * 2^k clocks
    generate
        for (genvar g = 0; g < RES_BITS; g++) begin : g_win
            assign win_m1[g] = CNT_W'((BASE_TICKS << g) - 1);
        end
    endgenerate

    // Accumulator with the bit decided in this window merged in
    always_comb begin
        acc_nx        = acc_q;
        acc_nx[idx_q] = cmp_s;
    end

    // Timer reload requests and the conversion-finished strobe
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    tmr_val  = DISCH_M1;
                end
            end
            ST_DISCH: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = win_m1[RES_BITS-1];
                end
            end
            ST_WIN: begin
                if (tmr_last) begin
                    if (idx_q == '0) begin
                        finish = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = win_m1[idx_q - 1'b1];
                    end
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing, drive polarity, bit decisions and result update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            acc_q    <= '0;
            rc_drive <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    rc_drive <= 1'b0;
                    if (start) state_q <= ST_DISCH;
                end
                ST_DISCH: begin
                    if (tmr_last) begin
                        state_q  <= ST_WIN;
                        idx_q    <= MSB_IDX;
                        rc_drive <= 1'b1;
                    end
                end
                ST_WIN: begin
                    if (tmr_last) begin
                        acc_q <= acc_nx;
                        if (idx_q == '0) begin
                            state_q  <= ST_IDLE;
                            rc_drive <= 1'b0;
                            done     <= 1'b1;
                            result   <= acc_nx;
                        end else begin
                            idx_q    <= idx_q - 1'b1;
                            rc_drive <= cmp_s;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rcsar_ctrl.sv
`timescale 1ns/1ps
// RC-ramp successive approximation controller, top level.
// Joins the comparator synchroniser, the window timer, the sequencer and
// the channel pointer.
// Assumes: RES_BITS >= 2, NUM_CH >= 1, DISCH_CYCLES >= 1, and
// BASE_TICKS >= 3 so that the shortest window outlasts the synchroniser.
module rcsar_ctrl #(
    parameter  int RES_BITS     = 8,
    parameter  int BASE_TICKS   = 4,
    parameter  int DISCH_CYCLES = 64,
    parameter  int NUM_CH       = 4,
    localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cmp_in,
    output logic                rc_drive,
    output logic [CH_W-1:0]     ch_sel,
    output logic                done,
    output logic [RES_BITS-1:0] result
);

    localparam int MAX_WIN = BASE_TICKS << (RES_BITS - 1);
    localparam int MAX_LEN = (MAX_WIN > DISCH_CYCLES) ? MAX_WIN : DISCH_CYCLES;
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;

    logic                  cmp_s;
    logic                  tmr_load;
    logic [CNT_W-1:0]      tmr_val;
    logic                  tmr_last;
    logic                  finish;
    rcsar_pkg::seq_state_t seq_state;

    rcsar_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_in),
        .q_sync  (cmp_s)
    );

    rcsar_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    rcsar_seq #(
        .RES_BITS     (RES_BITS),
        .BASE_TICKS   (BASE_TICKS),
        .DISCH_CYCLES (DISCH_CYCLES),
        .CNT_W        (CNT_W),
        .IDX_W        (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_s    (cmp_s),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .finish   (finish),
        .rc_drive (rc_drive),
        .done     (done),
        .result   (result),
        .state_o  (seq_state)
    );

    rcsar_chan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chan (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (finish),
        .ch    (ch_sel)
    );

endmodule

// File: rtl/rcsar_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for rcsar_ctrl, attached by bind.
// Assumes: 'st' is the sequencer phase from inside the top module.
module rcsar_ctrl_chk #(
    parameter int RES_BITS = 8,
    parameter int NUM_CH   = 4,
    parameter int CH_W     = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rc_drive,
    input logic                  done,
    input logic [RES_BITS-1:0]   result,
    input logic [CH_W-1:0]       ch_sel,
    input rcsar_pkg::seq_state_t st
);
    import rcsar_pkg::*;

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    p_disch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISCH) |-> !rc_drive);

    p_first_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIN && $past(st) == ST_DISCH) |-> rc_drive);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st == ST_IDLE));

    p_ch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ch_sel));

    p_ch_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ch_sel == (($past(ch_sel) == LAST_CH) ? '0 : $past(ch_sel) + 1'b1)));

    p_ch_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_sel <= LAST_CH);

    p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIN) |=> (st != ST_DISCH));

    p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !rc_drive);

endmodule

bind rcsar_ctrl rcsar_ctrl_chk #(
    .RES_BITS (RES_BITS),
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rc_drive (rc_drive),
    .done     (done),
    .result   (result),
    .ch_sel   (ch_sel),
    .st       (seq_state)
);

// File: tb/rcsar_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for rcsar_ctrl: one task per scenario, each self-checking.
module rcsar_ctrl_tb;

    localparam int RES   = 5;
    localparam int BASE  = 4;
    localparam int DISCH = 6;
    localparam int NCH   = 3;
    localparam int CHW   = 2;
    localparam int NO_INJ = -1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           cmp_in = 1'b0;
    logic           rc_drive;
    logic           done;
    logic [CHW-1:0] ch_sel;
    logic [RES-1:0] result;

    int n_chk = 0;
    int n_err = 0;
    logic [RES-1:0] exp_res = '0;
    int exp_ch = 0;

    always #2.5 clk = ~clk;

    rcsar_ctrl #(
        .RES_BITS     (RES),
        .BASE_TICKS   (BASE),
        .DISCH_CYCLES (DISCH),
        .NUM_CH       (NCH)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_in   (cmp_in),
        .rc_drive (rc_drive),
        .ch_sel   (ch_sel),
        .done     (done),
        .result   (result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // One conversion with comparator level pat[k] during window k.
    // inj_k = RES puts a stray start in the discharge period, 0..RES-1 into
    // that window, NO_INJ for none. Returns at the negedge of the done cycle.
    task automatic run_conv(input logic [RES-1:0] pat, input int inj_k);
        bit bad;
        int bad_drv;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bad = 0;
        bad_drv = 0;
        for (int i = 0; i < DISCH; i++) begin
            start = (inj_k == RES && i == 2);
            if (rc_drive !== 1'b0 || done !== 1'b0 || result !== exp_res ||
                ch_sel !== CHW'(exp_ch)) begin
                bad = 1;
                bad_drv = rc_drive;
            end
            @(negedge clk);
        end
        // R2 discharge low for DISCH cycles; R9 start in discharge ignored
        check(!bad, "R2/R9", "discharge drive", bad_drv, 0);
        for (int k = RES - 1; k >= 0; k--) begin
            logic exp_drv;
            exp_drv = (k == RES - 1) ? 1'b1 : pat[k+1];
            bad = 0;
            bad_drv = exp_drv;
            for (int c = 0; c < (BASE << k); c++) begin
                if (c == 0) cmp_in = pat[k];
                start = (inj_k == k && c == 1);
                if (rc_drive !== exp_drv || done !== 1'b0 || result !== exp_res ||
                    ch_sel !== CHW'(exp_ch)) begin
                    bad = 1;
                    bad_drv = rc_drive;
                end
                @(negedge clk);
            end
            // R3 first window high; R4 window length; R5 polarity; R9 hold
            if (k == RES - 1) check(!bad, "R3/R4", "MSB window drive", bad_drv, exp_drv);
            else              check(!bad, "R4/R5", "window drive", bad_drv, exp_drv);
        end
        start = 1'b0;
        exp_res = pat;
        exp_ch = (exp_ch + 1) % NCH;
        check(done === 1'b1, "R7", "done after LSB window", done, 1);
        check(result === pat, "R6", "result code", result, pat);
        check(ch_sel === CHW'(exp_ch), "R8", "channel advance", ch_sel, exp_ch);
        check(rc_drive === 1'b0, "R11", "drive after LSB", rc_drive, 0);
    endtask

    // Idle cycle after done: pulse over, drive low, outputs held
    task automatic after_done();
        @(negedge clk);
        check(done === 1'b0, "R7", "done single pulse", done, 0);
        check(rc_drive === 1'b0 && result === exp_res, "R11",
              "idle drive/result hold", rc_drive, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(rc_drive === 1'b0 && done === 1'b0, "R1", "drive/done in reset",
              {rc_drive, done}, 0);
        check(result === '0 && ch_sel === '0, "R1", "result/ch in reset",
              {result, ch_sel}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(rc_drive === 1'b0 && done === 1'b0 && result === '0 && ch_sel === '0,
              "R1", "outputs after release", {rc_drive, done, result, ch_sel}, 0);
    endtask

    task automatic t_basic();
        run_conv(5'b10110, NO_INJ);
        after_done();
    endtask

    // All-zero then all-one codes; the third conversion wraps ch_sel (R8)
    task automatic t_extremes();
        run_conv(5'b00000, NO_INJ);
        after_done();
        run_conv(5'b11111, NO_INJ);
        after_done();
        check(ch_sel === '0, "R8", "wrap to channel 0", ch_sel, 0);
    endtask

    task automatic t_alternate();
        run_conv(5'b01010, NO_INJ);
        after_done();
        run_conv(5'b10101, NO_INJ);
        after_done();
    endtask

    // R9: stray starts in discharge, a middle window and the LSB window
    task automatic t_start_ignored();
        run_conv(5'b01101, RES);
        after_done();
        run_conv(5'b11001, 2);
        after_done();
        run_conv(5'b00110, 0);
        after_done();
    endtask

    // R10: a start in the done cycle begins the next conversion at once
    task automatic t_back_to_back();
        run_conv(5'b10011, NO_INJ);
        run_conv(5'b01100, NO_INJ);
        after_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_alternate();
        t_start_ignored();
        t_back_to_back();
        summary();
        $finish;
    end

endmodule